// File: doc/BRIEF.md
# Switch-Selected Quadrant Highlighter

This block produces the colour of each pixel on a 640x480 screen. An external timing generator supplies the pixel X and Y coordinates. The block splits the visible area into four equal quadrants, two across and two down. Two switch bits pick one of them. That quadrant is painted solid blue, and the other three are painted black. Coordinates outside the visible area are always painted black.

The block runs from a 50 MHz board clock. It divides that clock by two with a toggle register, which gives a 25 MHz pixel rate. The toggle is brought out as `pix_tick`, so the timing generator can step its coordinates in the same phase. Every state register in the block advances only on board-clock edges where `pix_tick` is high.

Data flows through these stages in order:
1. A two-stage synchroniser takes in the switch bits.
2. A bank of four per-quadrant colour registers holds the colour of each quadrant.
3. A registered output stage picks the colour for the current coordinates.

Top module: `quad_highlighter`

## Requirements
- R1: The output colour is 8 bits packed as red in bits 7:5, green in bits 4:2 and blue in bits 1:0. Highlight is 8'h03 (full blue) and black is 8'h00. No other value ever appears.
- R2: A pixel belongs to the right half when X >= 320 and to the bottom half when Y >= 240.
- R3: `sel_row` picks the top half (0) or the bottom half (1). `sel_col` picks the left half (0) or the right half (1). So row=0, col=1 highlights the top-right quadrant.
- R4: Exactly the selected quadrant is drawn in highlight. The other three quadrants are drawn black.
- R5: A pixel with X > 639 or Y > 479 is drawn black, whatever the selection.
- R6: `pix_tick` toggles on every board-clock edge after reset. Registers advance only on edges where `pix_tick` was high.
- R7: A coordinate change appears at the output after one pixel update. A switch change appears after exactly four pixel updates, and the output keeps the old colour for the first three.
- R8: When `rst_n` goes low, `pix_rgb` goes to black and `pix_tick` goes low at once, without waiting for a clock edge. Release takes effect through a two-flop synchroniser.
- R9: `pix_rgb` holds its value across board-clock edges where `pix_tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| sel_row | input | 1 | Switch: 0 = top half, 1 = bottom half |
| sel_col | input | 1 | Switch: 0 = left half, 1 = right half |
| pix_tick | output | 1 | Pixel-rate toggle; an update happens on the edge after it is seen high |
| pix_rgb | output | 8 | Registered packed RGB colour |

## Verification
The hardest behaviour to observe is the four-update switch latency. The switch passes through the synchroniser and the quadrant bank before the output stage sees it. Any slip in how stimulus lines up with the pixel-enable phase would hide an off-by-one stage. The bench therefore steps one pixel update at a time: it waits for `pix_tick` to be seen high, then for the following edge. It holds the coordinates inside one quadrant, flips both switch bits, and checks the colour after each of the four updates. The sweep over all four selections visits coordinates on both sides of every quadrant and screen boundary, including X = 1023 and Y = 1023.

// File: rtl/qh_pkg.sv
package qh_pkg;

  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: 3'd0, g: 3'd0, b: 2'd0};
  localparam rgb_t RGB_HILITE = '{r: 3'd0, g: 3'd0, b: 2'd3};

  // quadrant index = {bottom_half, right_half}
  typedef enum logic [1:0] {
    QD_TL = 2'd0,
    QD_TR = 2'd1,
    QD_BL = 2'd2,
    QD_BR = 2'd3
  } quad_e;

  localparam int NUM_QUADS = 4;

endpackage

// File: rtl/qh_clkrst.sv
module qh_clkrst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n,
  output logic pix_en
);

  logic [1:0] rst_pipe;
  logic       tick_q;
  logic       tick_d;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_int_n = rst_pipe[1];

  always_comb begin
    tick_d = ~tick_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) tick_q <= 1'b0;
    else            tick_q <= tick_d;
  end

  assign pix_en = tick_q;

endmodule

// File: rtl/qh_sync.sv
module qh_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = en ? din : stage_q[s];
    end else begin : g_next
      always_comb stage_d[s] = en ? stage_q[s-1] : stage_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qh_quad_regs.sv
module qh_quad_regs
  import qh_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [1:0]                 sel,
  output rgb_t [NUM_QUADS-1:0]       quad_col
);

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    logic hit;
    rgb_t col_d;

    always_comb begin
      hit   = (sel == 2'(q));
      col_d = quad_col[q];
      if (en) col_d = hit ? RGB_HILITE : RGB_BLACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quad_col[q] <= RGB_BLACK;
      else        quad_col[q] <= col_d;
    end
  end

endmodule

// File: rtl/qh_pixel_out.sv
module qh_pixel_out
  import qh_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [COORD_W-1:0]   pix_x,
  input  logic [COORD_W-1:0]   pix_y,
  input  rgb_t [NUM_QUADS-1:0] quad_col,
  output rgb_t                 rgb_q
);

  localparam logic [COORD_W-1:0] H_LIM   = COORD_W'(H_ACTIVE);
  localparam logic [COORD_W-1:0] V_LIM   = COORD_W'(V_ACTIVE);
  localparam logic [COORD_W-1:0] H_SPLIT = COORD_W'(H_ACTIVE / 2);
  localparam logic [COORD_W-1:0] V_SPLIT = COORD_W'(V_ACTIVE / 2);

  logic  visible;
  quad_e idx;
  rgb_t  rgb_d;

  always_comb begin
    visible = (pix_x < H_LIM) && (pix_y < V_LIM);
    idx     = quad_e'({pix_y >= V_SPLIT, pix_x >= H_SPLIT});
    rgb_d   = rgb_q;
    if (en) rgb_d = visible ? quad_col[idx] : RGB_BLACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= RGB_BLACK;
    else        rgb_q <= rgb_d;
  end

endmodule

// File: rtl/quad_highlighter.sv
module quad_highlighter
  import qh_pkg::*;
#(
  parameter int COORD_W     = 10,
  parameter int H_ACTIVE    = 640,
  parameter int V_ACTIVE    = 480,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               sel_row,
  input  logic               sel_col,
  output logic               pix_tick,
  output logic [7:0]         pix_rgb
);

  logic                 rst_int_n;
  logic                 pix_en;
  logic [1:0]           sel_sync;
  rgb_t [NUM_QUADS-1:0] quad_col;
  rgb_t                 rgb_q;

  qh_clkrst u_clkrst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n),
    .pix_en    (pix_en)
  );

  qh_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (pix_en),
    .din   ({sel_row, sel_col}),
    .dout  (sel_sync)
  );

  qh_quad_regs u_quads (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (pix_en),
    .sel      (sel_sync),
    .quad_col (quad_col)
  );

  qh_pixel_out #(
    .COORD_W  (COORD_W),
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (pix_en),
    .pix_x    (pix_x),
    .pix_y    (pix_y),
    .quad_col (quad_col),
    .rgb_q    (rgb_q)
  );

  assign pix_tick = pix_en;
  assign pix_rgb  = rgb_q;

endmodule

// File: rtl/qh_checker.sv
module qh_checker
  import qh_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_int_n,
  input logic                 pix_tick,
  input logic [COORD_W-1:0]   pix_x,
  input logic [COORD_W-1:0]   pix_y,
  input logic [7:0]           pix_rgb,
  input rgb_t [NUM_QUADS-1:0] quad_col
);

  localparam logic [COORD_W-1:0] H_LIM = COORD_W'(H_ACTIVE);
  localparam logic [COORD_W-1:0] V_LIM = COORD_W'(V_ACTIVE);

  a_r1_legal_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rgb == 8'h00) || (pix_rgb == 8'h03));

  a_r4_single_hilite: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({quad_col[3] == RGB_HILITE, quad_col[2] == RGB_HILITE,
              quad_col[1] == RGB_HILITE, quad_col[0] == RGB_HILITE}));

  a_r5_offscreen_black: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_tick && ((pix_x >= H_LIM) || (pix_y >= V_LIM))) |=> (pix_rgb == 8'h00));

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pix_tick |=> $stable(pix_rgb));

  a_r8_reset_black: assert property (@(posedge clk)
    !rst_n |-> (pix_rgb == 8'h00 && !pix_tick));

endmodule

bind quad_highlighter qh_checker #(
  .COORD_W  (COORD_W),
  .H_ACTIVE (H_ACTIVE),
  .V_ACTIVE (V_ACTIVE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .pix_tick  (pix_tick),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .pix_rgb   (pix_rgb),
  .quad_col  (quad_col)
);

// File: tb/tb_quad_highlighter.sv
`timescale 1ns/1ps
module tb_quad_highlighter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] pix_x;
  logic [9:0] pix_y;
  logic       sel_row;
  logic       sel_col;
  logic       pix_tick;
  logic [7:0] pix_rgb;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  quad_highlighter dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_x    (pix_x),
    .pix_y    (pix_y),
    .sel_row  (sel_row),
    .sel_col  (sel_col),
    .pix_tick (pix_tick),
    .pix_rgb  (pix_rgb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (x=%0d y=%0d row=%0b col=%0b)",
               req, act, exp, pix_x, pix_y, sel_row, sel_col);
    end
  endtask

  // advance exactly one pixel update, ending on a falling edge
  task automatic step();
    while (pix_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] model(input int x, input int y, input logic r, input logic c);
    if (x > 639 || y > 479) return 8'h00;
    if ((r == (y >= 240)) && (c == (x >= 320))) return 8'h03;
    return 8'h00;
  endfunction

  int xs[12] = '{0, 1, 318, 319, 320, 321, 500, 638, 639, 640, 700, 1023};
  int ys[12] = '{0, 1, 120, 238, 239, 240, 241, 400, 478, 479, 480, 1023};

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_x = '0; pix_y = '0; sel_row = 1'b0; sel_col = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset colour", pix_rgb, 8'h00);
    check("R8 reset tick", {7'd0, pix_tick}, 8'h00);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R6: tick alternates at consecutive falling edges
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = pix_tick;
      @(negedge clk);
      check("R6 tick toggles", {7'd0, pix_tick}, {7'd0, ~prev});
    end

    // R2 R3 R4 R5 sweep over every selection and boundary coordinate
    for (int s = 0; s < 4; s++) begin
      sel_row = s[1];
      sel_col = s[0];
      repeat (5) step();
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          pix_x = 10'(xs[i]);
          pix_y = 10'(ys[j]);
          step();
          check("R2 R3 R4 R5 quadrant colour", pix_rgb, model(xs[i], ys[j], sel_row, sel_col));
        end
      end
    end

    // R9: value held across an edge with tick low
    for (int i = 0; i < 4; i++) begin
      logic [7:0] held;
      while (pix_tick !== 1'b0) @(negedge clk);
      held = pix_rgb;
      pix_x = 10'(i * 200);
      @(negedge clk);
      check("R9 hold at idle edge", pix_rgb, held);
      step();
    end

    // R7: switch latency of four updates, top-left held
    pix_x = 10'd5; pix_y = 10'd5;
    sel_row = 1'b0; sel_col = 1'b0;
    repeat (6) step();
    check("R7 settled before flip", pix_rgb, 8'h03);
    sel_row = 1'b1; sel_col = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      check("R7 old colour during latency", pix_rgb, 8'h03);
    end
    step();
    check("R7 new colour at fourth update", pix_rgb, 8'h00);
    pix_x = 10'd600; pix_y = 10'd400;
    step();
    check("R7 coordinate latency one update", pix_rgb, 8'h03);

    // R8: asynchronous clear mid-run
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R8 async clear colour", pix_rgb, 8'h00);
    check("R8 async clear tick", {7'd0, pix_tick}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) step();
    check("R1 R4 blue after re-reset", pix_rgb, 8'h03);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule